// File: doc/BRIEF.md
# Thermal Alert Comparator with Consecutive-Fault Filter

This block watches a stream of 12-bit temperature results and drives a single alert pin. Each time a conversion result is presented with its valid strobe, the block compares it, as a signed two's complement value at 0.0625 °C per LSB, against a high threshold and a low threshold. A small fault filter makes the alert change only after a programmed number of consecutive conversions meet the current trigger condition.

Two behaviours are selectable. In comparator mode the pin tracks a hysteresis band: it goes active above the high threshold and returns inactive below the low threshold. In interrupt mode the pin latches an event and stays active until software reads any register or the device answers an alert-response cycle. After each clear, the next event it waits for switches between a high crossing and a low crossing. The block holds the two threshold registers and the mode and fault-count settings. A general-reset strobe restores all of them.

Top module: `thermal_alert`

## Requirements
- R1: After reset, the alert is inactive (`alertPin` = 1, since the pin is active low by default). The high threshold is 0x500 (80 °C) and the low threshold is 0x4B0 (75 °C). The mode is comparator (`cfgIntMode` = 0) and the fault code is 00.
- R2: In comparator mode with the alert inactive, a conversion whose signed value is greater than or equal to the high threshold counts as a fault. When the required count is reached, `alertPin` goes active on the clock edge that captures that conversion.
- R3: In comparator mode with the alert active, only conversions strictly below the low threshold count. When the required count is reached, the alert goes inactive. Values at or above the low threshold never clear it.
- R4: Fault code 00, 01, 10 and 11 requires 1, 2, 4 and 6 consecutive faulting conversions.
- R5: A conversion that does not meet the current trigger condition restarts the consecutive count. So does any write to the mode/fault-code settings.
- R6: Comparisons are signed and use all 12 bits of the temperature and both thresholds. A threshold LSB of value 1 changes the outcome.
- R7: In interrupt mode (`cfgIntMode` = 1), the required count of conversions at or above the high threshold makes the alert active. It then stays active, and further conversions are ignored, until a clear event occurs.
- R8: In interrupt mode, a `regRead` or `alertRespOk` pulse clears a pending alert in the next cycle. When no alert is pending, these pulses have no effect.
- R9: In interrupt mode, each clear swaps the armed event. After a high event is cleared, only conversions strictly below the low threshold can raise the alert. After that event is cleared, the block waits for the high threshold again.
- R10: In interrupt mode, a rising edge on `shutdown` clears a pending alert and swaps the armed event, just as R8 does.
- R11: In comparator mode, `regRead`, `alertRespOk` and `shutdown` have no effect on the alert.
- R12: A settings write that changes the mode clears the alert, clears the count and arms the high-threshold event.
- R13: A `genReset` pulse clears the alert and restores the R1 values of the thresholds, mode and fault code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| convValid | input | 1 | A new conversion result is on convTemp |
| convTemp | input | 12 | Signed temperature, 0.0625 °C per LSB |
| hiWr | input | 1 | Load hiData into the high threshold |
| hiData | input | 12 | New high threshold value |
| loWr | input | 1 | Load loData into the low threshold |
| loData | input | 12 | New low threshold value |
| cfgWr | input | 1 | Load the mode and fault-code settings |
| cfgIntMode | input | 1 | 0 = comparator, 1 = interrupt |
| cfgFaultCode | input | 2 | Consecutive-fault code |
| regRead | input | 1 | Pulse: some register was read |
| alertRespOk | input | 1 | Pulse: alert-response cycle answered |
| shutdown | input | 1 | Shutdown level; the rising edge matters |
| genReset | input | 1 | Pulse: general reset of the settings |
| alertPin | output | 1 | Alert output, active low by default |

## Verification
The hardest state to reach is interrupt mode armed for the low event with an alert pending. To get there, the stimulus must first raise a high event, clear it, and then present low conversions. That path is why the interrupt sequence runs high, read, low, response, high, shutdown, low. Another hard case is a count that is broken one conversion short of its target. The stimulus builds three faults toward a target of four, inserts one non-faulting value, and shows that three more faults still leave the alert inactive. A behavioural reference model in the bench follows every cycle, so timing slips of one clock are caught as well.

// File: rtl/thermal_alert_pkg.sv
package thermal_alert_pkg;
  localparam int MAX_FAULTS = 6;
  localparam int NEED_W = $clog2(MAX_FAULTS + 1);

  typedef struct packed {
    logic cntInc;
    logic cntClr;
  } faultStrobes_t;

  function automatic logic [NEED_W-1:0] faultNeed(input logic [1:0] code);
    case (code)
      2'd0:    faultNeed = NEED_W'(1);
      2'd1:    faultNeed = NEED_W'(2);
      2'd2:    faultNeed = NEED_W'(4);
      default: faultNeed = NEED_W'(MAX_FAULTS);
    endcase
  endfunction
endpackage

// File: rtl/thermal_alert_datapath.sv
module thermal_alert_datapath
  import thermal_alert_pkg::*;
#(
  parameter int TEMP_W = 12,
  parameter logic [TEMP_W-1:0] HI_RESET = 12'h500,
  parameter logic [TEMP_W-1:0] LO_RESET = 12'h4B0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              genReset,
  input  logic              hiWr,
  input  logic [TEMP_W-1:0] hiData,
  input  logic              loWr,
  input  logic [TEMP_W-1:0] loData,
  input  logic              cfgWr,
  input  logic              cfgIntMode,
  input  logic [1:0]        cfgFaultCode,
  input  logic [TEMP_W-1:0] convTemp,
  input  faultStrobes_t     strobes,
  output logic              geHigh,
  output logic              ltLow,
  output logic              countHit,
  output logic              modeInt,
  output logic              modeChange
);
  localparam int CNT_W = NEED_W;

  logic [TEMP_W-1:0] hiLim, loLim;
  logic [1:0]        faultCode;
  logic [CNT_W-1:0]  faultCnt;
  logic [CNT_W-1:0]  cntPlus;

  assign geHigh     = $signed(convTemp) >= $signed(hiLim);
  assign ltLow      = $signed(convTemp) <  $signed(loLim);
  assign cntPlus    = faultCnt + CNT_W'(1);
  assign countHit   = cntPlus >= faultNeed(faultCode);
  assign modeChange = cfgWr && (cfgIntMode != modeInt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiLim     <= HI_RESET;
      loLim     <= LO_RESET;
      modeInt   <= 1'b0;
      faultCode <= 2'd0;
    end else if (genReset) begin
      hiLim     <= HI_RESET;
      loLim     <= LO_RESET;
      modeInt   <= 1'b0;
      faultCode <= 2'd0;
    end else begin
      if (hiWr) hiLim <= hiData;
      if (loWr) loLim <= loData;
      if (cfgWr) begin
        modeInt   <= cfgIntMode;
        faultCode <= cfgFaultCode;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           faultCnt <= '0;
    else if (genReset || cfgWr)          faultCnt <= '0;
    else if (strobes.cntClr)             faultCnt <= '0;
    else if (strobes.cntInc)             faultCnt <= cntPlus;
  end

  assert_cnt_below_need_R4: assert property (@(posedge clk) disable iff (!rstN)
    faultCnt < faultNeed(faultCode));

  assert_genreset_limits_R13: assert property (@(posedge clk) disable iff (!rstN)
    genReset |=> (hiLim == HI_RESET && loLim == LO_RESET && !modeInt));

  assert_cfg_restarts_count_R5: assert property (@(posedge clk) disable iff (!rstN)
    cfgWr |=> (faultCnt == '0));
endmodule

// File: rtl/thermal_alert_ctrl.sv
module thermal_alert_ctrl
  import thermal_alert_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          genReset,
  input  logic          convValid,
  input  logic          regRead,
  input  logic          alertRespOk,
  input  logic          shutdown,
  input  logic          geHigh,
  input  logic          ltLow,
  input  logic          countHit,
  input  logic          modeInt,
  input  logic          modeChange,
  output faultStrobes_t strobes,
  output logic          alertActive
);
  logic armHigh, shutPrev, shutRise, trig, clrEvt;
  logic alertNext, armNext;

  assign shutRise = shutdown && !shutPrev;
  assign clrEvt   = modeInt && alertActive && (regRead || alertRespOk || shutRise);
  assign trig     = modeInt ? (armHigh ? geHigh : ltLow)
                            : (alertActive ? ltLow : geHigh);

  always_comb begin
    alertNext = alertActive;
    armNext   = armHigh;
    strobes   = '0;
    if (modeChange) begin
      alertNext      = 1'b0;
      armNext        = 1'b1;
      strobes.cntClr = 1'b1;
    end else if (clrEvt) begin
      alertNext      = 1'b0;
      armNext        = !armHigh;
      strobes.cntClr = 1'b1;
    end else if (convValid && !(modeInt && alertActive)) begin
      if (!trig) begin
        strobes.cntClr = 1'b1;
      end else if (countHit) begin
        alertNext      = modeInt ? 1'b1 : !alertActive;
        strobes.cntClr = 1'b1;
      end else begin
        strobes.cntInc = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      alertActive <= 1'b0;
      armHigh     <= 1'b1;
      shutPrev    <= 1'b0;
    end else begin
      shutPrev <= shutdown;
      if (genReset) begin
        alertActive <= 1'b0;
        armHigh     <= 1'b1;
      end else begin
        alertActive <= alertNext;
        armHigh     <= armNext;
      end
    end
  end

  assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    (modeInt && alertActive && (regRead || alertRespOk)) |=> !alertActive);

  assert_shutdown_clears_R10: assert property (@(posedge clk) disable iff (!rstN)
    (modeInt && alertActive && shutdown && !shutPrev) |=> !alertActive);

  assert_int_holds_R7: assert property (@(posedge clk) disable iff (!rstN)
    (modeInt && alertActive && !regRead && !alertRespOk && !shutRise
     && !modeChange && !genReset) |=> alertActive);

  assert_comp_ignores_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!modeInt && !convValid && !modeChange && !genReset) |=> $stable(alertActive));

  assert_genreset_clears_R13: assert property (@(posedge clk) disable iff (!rstN)
    genReset |=> !alertActive);

  assert_strobes_exclusive_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.cntInc && strobes.cntClr));
endmodule

// File: rtl/thermal_alert.sv
module thermal_alert
  import thermal_alert_pkg::*;
#(
  parameter int TEMP_W = 12,
  parameter bit ACTIVE_LOW = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              convValid,
  input  logic [TEMP_W-1:0] convTemp,
  input  logic              hiWr,
  input  logic [TEMP_W-1:0] hiData,
  input  logic              loWr,
  input  logic [TEMP_W-1:0] loData,
  input  logic              cfgWr,
  input  logic              cfgIntMode,
  input  logic [1:0]        cfgFaultCode,
  input  logic              regRead,
  input  logic              alertRespOk,
  input  logic              shutdown,
  input  logic              genReset,
  output logic              alertPin
);
  localparam logic [TEMP_W-1:0] HI_RESET = TEMP_W'(80 * 16);
  localparam logic [TEMP_W-1:0] LO_RESET = TEMP_W'(75 * 16);

  faultStrobes_t strobes;
  logic geHigh, ltLow, countHit, modeInt, modeChange, alertActive;

  thermal_alert_datapath #(
    .TEMP_W(TEMP_W), .HI_RESET(HI_RESET), .LO_RESET(LO_RESET)
  ) u_dp (
    .clk(clk), .rstN(rstN), .genReset(genReset),
    .hiWr(hiWr), .hiData(hiData), .loWr(loWr), .loData(loData),
    .cfgWr(cfgWr), .cfgIntMode(cfgIntMode), .cfgFaultCode(cfgFaultCode),
    .convTemp(convTemp), .strobes(strobes),
    .geHigh(geHigh), .ltLow(ltLow), .countHit(countHit),
    .modeInt(modeInt), .modeChange(modeChange)
  );

  thermal_alert_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .genReset(genReset), .convValid(convValid),
    .regRead(regRead), .alertRespOk(alertRespOk), .shutdown(shutdown),
    .geHigh(geHigh), .ltLow(ltLow), .countHit(countHit),
    .modeInt(modeInt), .modeChange(modeChange),
    .strobes(strobes), .alertActive(alertActive)
  );

  generate
    if (ACTIVE_LOW) begin : g_low
      assign alertPin = !alertActive;
    end else begin : g_high
      assign alertPin = alertActive;
    end
  endgenerate
endmodule

// File: tb/thermal_alert_test.sv
module thermal_alert_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic convValid = 0, hiWr = 0, loWr = 0, cfgWr = 0, cfgIntMode = 0;
  logic regRead = 0, alertRespOk = 0, shutdown = 0, genReset = 0;
  logic [11:0] convTemp = '0, hiData = '0, loData = '0;
  logic [1:0] cfgFaultCode = '0;
  logic alertPin;

  int checks = 0, fails = 0;
  string phase = "R1";

  // reference model state
  bit mAlert, mArmHigh, mInt, mShPrev;
  int mCnt, mCode, mHi, mLo;

  thermal_alert uut (
    .clk(clk), .rstN(rstN), .convValid(convValid), .convTemp(convTemp),
    .hiWr(hiWr), .hiData(hiData), .loWr(loWr), .loData(loData),
    .cfgWr(cfgWr), .cfgIntMode(cfgIntMode), .cfgFaultCode(cfgFaultCode),
    .regRead(regRead), .alertRespOk(alertRespOk), .shutdown(shutdown),
    .genReset(genReset), .alertPin(alertPin)
  );

  always #10 clk = ~clk;

  function automatic int toSigned(input logic [11:0] v);
    return v[11] ? int'(v) - 4096 : int'(v);
  endfunction

  function automatic int needOf(input int code);
    int t [4] = '{1, 2, 4, 6};
    return t[code];
  endfunction

  task automatic modelDefaults();
    mAlert = 0; mArmHigh = 1; mInt = 0; mCnt = 0; mCode = 0;
    mHi = 1280; mLo = 1200;
  endtask

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modelDefaults();
      mShPrev = 0;
    end else begin
      bit rise, hitCond;
      int t;
      rise = shutdown && !mShPrev;
      mShPrev = shutdown;
      t = toSigned(convTemp);
      if (genReset) begin
        modelDefaults();
      end else begin
        if (cfgWr && (cfgIntMode != mInt)) begin
          mAlert = 0; mArmHigh = 1; mCnt = 0;
        end else if (mInt && mAlert && (regRead || alertRespOk || rise)) begin
          mAlert = 0; mArmHigh = !mArmHigh; mCnt = 0;
        end else if (convValid && !(mInt && mAlert)) begin
          if (mInt) hitCond = mArmHigh ? (t >= mHi) : (t < mLo);
          else      hitCond = mAlert ? (t < mLo) : (t >= mHi);
          if (hitCond) begin
            mCnt++;
            if (mCnt >= needOf(mCode)) begin
              mAlert = mInt ? 1'b1 : !mAlert;
              mCnt = 0;
            end
          end else mCnt = 0;
        end
        if (cfgWr) begin
          mCnt = 0; mInt = cfgIntMode; mCode = int'(cfgFaultCode);
        end
        if (hiWr) mHi = toSigned(hiData);
        if (loWr) mLo = toSigned(loData);
      end
    end
  end

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      checks++;
      if (alertPin !== !mAlert) begin
        fails++;
        $display("FAIL %s model compare: alertPin=%0b expected=%0b", phase, alertPin, !mAlert);
      end
    end
  end

  task automatic expectActive(input bit act, input string req);
    checks++;
    if (alertPin !== !act) begin
      fails++;
      $display("FAIL %s: alertPin=%0b expected=%0b", req, alertPin, !act);
    end
  endtask

  task automatic conv(input logic [11:0] t);
    convValid = 1; convTemp = t;
    @(negedge clk);
    convValid = 0;
  endtask

  task automatic convN(input logic [11:0] t, input int n);
    for (int i = 0; i < n; i++) conv(t);
  endtask

  task automatic setCfg(input bit intMode, input logic [1:0] code);
    cfgWr = 1; cfgIntMode = intMode; cfgFaultCode = code;
    @(negedge clk);
    cfgWr = 0;
  endtask

  task automatic setLimits(input logic [11:0] hi, input logic [11:0] lo);
    hiWr = 1; hiData = hi; loWr = 1; loData = lo;
    @(negedge clk);
    hiWr = 0; loWr = 0;
  endtask

  task automatic pulse(input int which);
    case (which)
      0: regRead = 1;
      1: alertRespOk = 1;
      default: genReset = 1;
    endcase
    @(negedge clk);
    regRead = 0; alertRespOk = 0; genReset = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    phase = "R1"; expectActive(0, "R1 reset inactive");

    phase = "R2";
    conv(12'h4FF); expectActive(0, "R2 below high");
    conv(12'h500); expectActive(1, "R2 equal high asserts");
    phase = "R3";
    conv(12'h4B0); expectActive(1, "R3 equal low holds");
    conv(12'h4AF); expectActive(0, "R3 below low clears");

    phase = "R5";
    setCfg(0, 2'd2);
    convN(12'h600, 3); conv(12'h400); convN(12'h600, 3);
    expectActive(0, "R5 broken run restarts count");
    phase = "R4";
    conv(12'h600); expectActive(1, "R4 code 10 needs 4");
    phase = "R5";
    convN(12'h400, 3); conv(12'h4B0); convN(12'h400, 3);
    expectActive(1, "R5 low run restarted");
    conv(12'h400); expectActive(0, "R3 four lows clear");

    phase = "R4";
    setCfg(0, 2'd3);
    convN(12'h600, 5); expectActive(0, "R4 code 11 five short");
    conv(12'h600); expectActive(1, "R4 code 11 six asserts");
    convN(12'h100, 6); expectActive(0, "R4 six lows clear");
    setCfg(0, 2'd1);
    conv(12'h600); expectActive(0, "R4 code 01 one short");
    conv(12'h600); expectActive(1, "R4 code 01 two asserts");
    convN(12'h100, 2); expectActive(0, "R4 code 01 clears");

    phase = "R6";
    setCfg(0, 2'd0);
    setLimits(12'hFF0, 12'hFE0);
    conv(12'h100); expectActive(1, "R6 signed positive over negative high");
    conv(12'hFE0); expectActive(1, "R6 equal negative low holds");
    conv(12'hFDF); expectActive(0, "R6 below negative low clears");
    setLimits(12'h501, 12'h4B0);
    conv(12'h500); expectActive(0, "R6 high LSB matters");
    conv(12'h501); expectActive(1, "R6 high LSB reached");
    conv(12'h4AF);

    phase = "R7";
    setCfg(1, 2'd0); expectActive(0, "R12 enter interrupt inactive");
    conv(12'h600); expectActive(1, "R7 interrupt high asserts");
    conv(12'h100); expectActive(1, "R7 pending ignores low");
    phase = "R8";
    pulse(0); expectActive(0, "R8 read clears");
    phase = "R9";
    conv(12'h600); expectActive(0, "R9 high ignored when armed low");
    conv(12'h400); expectActive(1, "R9 low event asserts");
    phase = "R8";
    pulse(1); expectActive(0, "R8 alert response clears");
    phase = "R9";
    conv(12'h400); expectActive(0, "R9 low ignored when armed high");
    conv(12'h600); expectActive(1, "R9 re-armed high asserts");
    phase = "R10";
    shutdown = 1; @(negedge clk); expectActive(0, "R10 shutdown edge clears");
    @(negedge clk); shutdown = 0; @(negedge clk);
    conv(12'h400); expectActive(1, "R10 swap to low event");

    phase = "R12";
    setCfg(0, 2'd0); expectActive(0, "R12 mode change clears");
    phase = "R11";
    conv(12'h600); expectActive(1, "R11 comparator asserts");
    pulse(0); pulse(1);
    shutdown = 1; @(negedge clk); shutdown = 0; @(negedge clk);
    expectActive(1, "R11 clears ignored in comparator");

    phase = "R8";
    setCfg(1, 2'd0);
    pulse(0); pulse(1);
    conv(12'h600); expectActive(1, "R8 no pending read keeps high arm");

    phase = "R13";
    pulse(2); expectActive(0, "R13 general reset clears");
    pulse(0); expectActive(0, "R13 stays inactive");
    conv(12'h500); expectActive(1, "R13 high limit restored, comparator");
    pulse(0); expectActive(1, "R13 comparator after reset");

    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule